// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a fast clock, standing in for the output of a voltage-controlled oscillator, and sits in the feedback path of a frequency synthesizer. It produces one single-cycle pulse for each divide period. The phase detector compares that pulse train with the reference. Two modes are available. In the full mode the ratio is built from a 12-bit coarse value N and a 4-bit fine code A, and an optional 6-bit offset adds a fraction in 1/64 steps. In the integer mode the ratio is N on its own.

The fraction comes from dithering between two adjacent integer ratios. A 6-bit phase accumulator adds the offset once per period. Each period in which that addition overflows is one input cycle longer. Configuration inputs take effect only when a period ends, so the output never carries a shortened or stretched pulse.

Top module: `frac_fb_div`

## Requirements
- R1: In full mode (`int_mode_i`=0) with `frac_en_i`=0 and a nonzero code `a_i`, each period lasts 2*N + A + 1 input cycles.
- R2: In full mode the code `a_i`=0 stands for the value -1, so the period is exactly 2*N cycles.
- R3: In full mode with `frac_en_i`=1, the k-th period after reset (k counted from 1) lasts M+1 cycles when floor(k*F/64) > floor((k-1)*F/64), and M cycles otherwise. M is the integer ratio from R1/R2 and F is `frac_off_i`. Over 64 periods the total is 64*M + F.
- R4: In integer mode (`int_mode_i`=1) each period lasts N cycles. `a_i`, `frac_off_i` and `frac_en_i` have no effect.
- R5: A computed integer ratio of 0 (N=0 in integer mode, or N=0 with code 0 in full mode) is treated as 1, so the block pulses as fast as possible. In full mode a fractional carry still adds one cycle.
- R6: Configuration is sampled only on the last cycle of a period. A change made inside a period leaves that period's length unchanged and applies from the next period.
- R7: `pulse_o` is high for exactly one input cycle, the last cycle of each period. After reset is released, the first pulse is visible after the L-th rising edge, where L is the first period length.
- R8: While `rst_ni` is low, `pulse_o` is low. Reset clears the period counter and the fraction accumulator, so dithering restarts from phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_i | input | 12 | Coarse divide value N |
| a_i | input | 4 | Fine code A (0 means -1), full mode only |
| frac_off_i | input | 6 | Fractional offset in 1/64 steps |
| frac_en_i | input | 1 | Enables fractional dithering in full mode |
| int_mode_i | input | 1 | 1 selects the integer-only ratio M = N |
| pulse_o | output | 1 | One-cycle pulse on the last cycle of each period |

## Verification
Each pulse is due on the L-th rising edge after the edge that ended the previous period. L is the length fixed on that earlier edge, and after reset the count starts from the first edge after release. The bench changes inputs only at falling edges and samples `pulse_o` at falling edges. It measures every period as a count of rising edges and compares that count with a length computed arithmetically from N, A, the offset and a model of the 6-bit phase. For the mid-period change, the new configuration is applied one cycle after a pulse. The bench then expects the old length for the current period and the new length for the one after it.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_INT  = 1'b1
  } div_mode_e;
endpackage

// File: rtl/div_ratio_calc.sv
module div_ratio_calc
  import frac_div_pkg::*;
#(
  parameter int NW = 12,
  parameter int AW = 4,
  parameter int LW = NW + 2
) (
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] a_i,
  input  div_mode_e     mode_i,
  input  logic          frac_en_i,
  output logic [LW-1:0] base_o,
  output logic          frac_act_o
);
  logic [LW-1:0] n_ext, two_n, full_m, raw_m;

  always_comb begin
    n_ext  = LW'(n_i);
    two_n  = n_ext << 1;
    // code 0 encodes -1, so 2N + (-1) + 1 = 2N
    full_m = (a_i == '0) ? two_n : two_n + LW'(a_i) + LW'(1);
    raw_m  = (mode_i == MODE_INT) ? n_ext : full_m;
    base_o = (raw_m == '0) ? LW'(1) : raw_m;
    frac_act_o = (mode_i == MODE_FULL) && frac_en_i;
  end
endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
  parameter int FW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          act_i,
  input  logic [FW-1:0] off_i,
  output logic          carry_o
);
  logic [FW-1:0] acc_q;
  logic [FW:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, off_i};
    carry_o = act_i & sum[FW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= act_i ? sum[FW-1:0] : '0;
  end
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int LW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] len_i,
  output logic          load_o,
  output logic          pulse_o
);
  logic [LW-1:0] cnt_q;

  assign load_o  = (cnt_q <= LW'(1));
  assign pulse_o = (cnt_q == LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_o) cnt_q <= len_i;
    else             cnt_q <= cnt_q - LW'(1);
  end

  AST_RELOAD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> cnt_q == $past(len_i)); // R6
  AST_NO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> cnt_q != '0); // R7
endmodule

// File: rtl/frac_fb_div.sv
module frac_fb_div
  import frac_div_pkg::*;
#(
  parameter int NW = 12,
  parameter int AW = 4,
  parameter int FW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] a_i,
  input  logic [FW-1:0] frac_off_i,
  input  logic          frac_en_i,
  input  logic          int_mode_i,
  output logic          pulse_o
);
  localparam int LW = NW + 2;

  div_mode_e     mode;
  logic [LW-1:0] base, len;
  logic          frac_act, carry, load;

  assign mode = div_mode_e'(int_mode_i);

  div_ratio_calc #(.NW(NW), .AW(AW), .LW(LW)) i_ratio (
    .n_i(n_i), .a_i(a_i), .mode_i(mode), .frac_en_i(frac_en_i),
    .base_o(base), .frac_act_o(frac_act)
  );

  frac_phase_acc #(.FW(FW)) i_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .act_i(frac_act),
    .off_i(frac_off_i), .carry_o(carry)
  );

  assign len = base + LW'(carry);

  period_counter #(.LW(LW)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .len_i(len),
    .load_o(load), .pulse_o(pulse_o)
  );

  AST_LEN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> len >= LW'(1)); // R5
  AST_INT_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && int_mode_i) |-> !carry); // R4
  AST_A0_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !int_mode_i && !frac_en_i && a_i == '0 && n_i != '0) |-> !len[0]); // R2
  AST_RST_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !pulse_o); // R8
endmodule

// File: tb/test_frac_fb_div.sv
module test_frac_fb_div;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] n_i = '0;
  logic [3:0]  a_i = '0;
  logic [5:0]  frac_off_i = '0;
  logic        frac_en_i = 1'b0;
  logic        int_mode_i = 1'b0;
  logic        pulse_o;

  int checks = 0;
  int failures = 0;
  int acc_m = 0;

  frac_fb_div i_frac_fb_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .n_i(n_i), .a_i(a_i),
    .frac_off_i(frac_off_i), .frac_en_i(frac_en_i),
    .int_mode_i(int_mode_i), .pulse_o(pulse_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int base_m(input int n, input int a, input bit im);
    int m;
    if (im) m = n;
    else if (a == 0) m = 2 * n;
    else m = 2 * n + a + 1;
    if (m == 0) m = 1;
    return m;
  endfunction

  // next expected length from the phase model; advances the model
  function automatic int next_len(input int n, input int a, input int off, input bit fe, input bit im);
    int s;
    int c;
    c = 0;
    if (fe && !im) begin
      s = acc_m + off;
      c = (s >= 64) ? 1 : 0;
      acc_m = s % 64;
    end else acc_m = 0;
    return base_m(n, a, im) + c;
  endfunction

  task automatic measure(output int len, input int limit);
    len = 0;
    do begin
      @(posedge clk_i);
      @(negedge clk_i);
      len++;
    end while (!pulse_o && len < limit);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check(pulse_o == 1'b0, "R8", int'(pulse_o), 0);
    acc_m = 0;
    rst_ni = 1'b1;
  endtask

  task automatic run_cfg(input int n, input int a, input int off, input bit fe,
                         input bit im, input int periods, input string req);
    int got;
    int exp;
    int tot;
    int m;
    n_i = 12'(n); a_i = 4'(a); frac_off_i = 6'(off);
    frac_en_i = fe; int_mode_i = im;
    do_reset();
    tot = 0;
    m = base_m(n, a, im);
    for (int p = 0; p < periods; p++) begin
      exp = next_len(n, a, off, fe, im);
      measure(got, exp + 4);
      tot += got;
      check(got == exp, req, got, exp);
    end
    if (periods == 64) check(tot == 64 * m + off, "R3 total", tot, 64 * m + off);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int got;
    repeat (2) @(negedge clk_i);
    check(pulse_o == 1'b0, "R8 reset", int'(pulse_o), 0);

    // full mode, fraction off: R1, R2, R5
    for (int n = 0; n < 6; n++)
      for (int a = 0; a < 16; a++)
        run_cfg(n, a, 37, 1'b0, 1'b0, 3,
                (n == 0 && a == 0) ? "R5" : (a == 0 ? "R2" : "R1"));

    // integer mode ignores a, offset and enable: R4, R5
    for (int n = 0; n < 25; n++)
      run_cfg(n, (n * 7) % 16, (n * 5) % 64, 1'b1, 1'b1, 3, (n == 0) ? "R5" : "R4");

    // fractional dithering: R3
    run_cfg(3, 0, 1, 1'b1, 1'b0, 64, "R3");
    run_cfg(3, 5, 17, 1'b1, 1'b0, 64, "R3");
    run_cfg(2, 9, 32, 1'b1, 1'b0, 64, "R3");
    run_cfg(4, 2, 63, 1'b1, 1'b0, 64, "R3");
    run_cfg(3, 3, 0, 1'b1, 1'b0, 64, "R3");
    run_cfg(0, 0, 32, 1'b1, 1'b0, 64, "R5");

    // largest ratios
    run_cfg(4095, 7, 9, 1'b0, 1'b1, 2, "R4");
    run_cfg(4095, 15, 0, 1'b0, 1'b0, 2, "R1");

    // reset restarts phase mid-stream: R8
    run_cfg(3, 1, 45, 1'b1, 1'b0, 10, "R8");
    run_cfg(3, 1, 45, 1'b1, 1'b0, 10, "R8");

    // mid-period change: R6, R7
    n_i = 12'd10; a_i = 4'd0; frac_off_i = '0; frac_en_i = 1'b0; int_mode_i = 1'b0;
    do_reset();
    measure(got, 30);
    check(got == 20, "R7 first", got, 20);
    @(posedge clk_i);
    @(negedge clk_i);
    n_i = 12'd3; a_i = 4'd2;
    measure(got, 30);
    check(got == 19, "R6 current", got + 1, 20);
    measure(got, 30);
    check(got == 9, "R6 next", got, 9);
    @(posedge clk_i);
    @(negedge clk_i);
    check(pulse_o == 1'b0, "R7 single", int'(pulse_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule